// File: doc/BRIEF.md
# Timestamp Recency Tracker with Selectable Insertion Position

This block holds the replacement metadata for one set of a set-associative cache: a valid bit and a recency stamp per way, plus a single running stamp counter for the cache. The surrounding cache controller reports two kinds of event. A touch marks a resident way as just used. An insert installs a new block into a way, either at the most-recent end of the recency order or at the least-recent end. The block always presents the way that a fill should replace.

Recency is kept as absolute stamps rather than a rank order. A touch, or an insert at the most-recent end, copies the counter into the way and then advances the counter. An insert at the least-recent end gives the new way a stamp one below the oldest valid stamp in the set, so it becomes the next victim. If the set holds no valid way, it falls back to the counter value. The counter advances on every accepted command. Its reset value is two raised to (log2 cache bytes − log2 block bytes + 1). Each cache level carries its own instance, so the two levels keep separate recency orders.

Top module: `lru_stamp_tracker`

## Requirements
- R1: After reset every way is invalid, every stamp reads 0, the victim output is way 0, and the counter holds 2^(CACHE_LOG2 − BLOCK_LOG2 + 1), which is 512 with the default parameters.
- R2: A touch (touch_i=1, ins_i=0) of a valid way sets that way's stamp to the counter value, and the counter then advances by one.
- R3: A touch of an invalid way changes no valid bit and no stamp, and does not advance the counter.
- R4: An insert with ins_low_i=0 sets the way valid, sets its stamp to the counter value, and advances the counter by one.
- R5: An insert with ins_low_i=1, into a set with at least one valid way, sets the way valid and gives it a stamp of (smallest stamp among ways valid before the insert) − 1. The way being replaced counts if it was valid. The counter advances by one.
- R6: An insert with ins_low_i=1 into a set with no valid way gives the new way the counter value, and the counter advances by one.
- R7: While any way is invalid, victim_o is the lowest-numbered invalid way.
- R8: While all ways are valid, victim_o is the way with the smallest stamp. On equal stamps the lowest index is chosen.
- R9: When touch_i and ins_i are both high in one cycle, only the insert takes effect and the counter advances once.
- R10: Stamps, valid bits and the counter change only at a rising clock edge. The victim output and the stamp read port (rd_stamp_o shows the stamp of way rd_way_i) follow the stored state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_i | input | 1 | Hit on way touch_way_i |
| touch_way_i | input | WAY_W | Way that was hit |
| ins_i | input | 1 | Install a block into ins_way_i |
| ins_way_i | input | WAY_W | Way receiving the block |
| ins_low_i | input | 1 | 1: insert at least-recent end, 0: most-recent end |
| rd_way_i | input | WAY_W | Way selected for stamp read |
| rd_stamp_o | output | STAMP_W | Stamp of way rd_way_i |
| valid_o | output | WAYS | Valid bit per way |
| victim_o | output | WAY_W | Way to replace on the next fill |

## Verification
The assertions assume that way indices stay below WAYS and that stamps never wrap. Under that assumption the smallest valid stamp minus one is a true new minimum, and the counter only grows. The stimulus draws way numbers only from the legal range. It picks reset parameters that put the counter at 512, and it stays short enough that repeated least-recent inserts cannot drive a stamp below zero or push the counter near its top. Touches on invalid ways and same-cycle touch and insert are issued on purpose, because the block must handle them.

// File: rtl/lru_stamp_pkg.sv
package lru_stamp_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_TOUCH  = 2'd1,
    CMD_INS_HI = 2'd2,
    CMD_INS_LO = 2'd3
  } cmd_e;
endpackage

// File: rtl/lru_stamp_argmin.sv
module lru_stamp_argmin #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 32,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][STAMP_W-1:0] stamps_i,
  input  logic [WAYS-1:0]              mask_i,
  output logic [WAY_W-1:0]             idx_o,
  output logic [STAMP_W-1:0]           min_o,
  output logic                         any_o
);
  always_comb begin
    idx_o = '0;
    min_o = '0;
    any_o = 1'b0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < WAYS; i++) begin
      if (mask_i[i] && (!any_o || stamps_i[i] < min_o)) begin
        idx_o = WAY_W'(i);
        min_o = stamps_i[i];
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lru_stamp_victim.sv
module lru_stamp_victim #(
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] oldest_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = WAY_W'(i);
        free_any = 1'b1;
      end
    end
    victim_o = free_any ? free_idx : oldest_i;
  end
endmodule

// File: rtl/lru_stamp_store.sv
module lru_stamp_store
  import lru_stamp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int STAMP_W    = 32,
  parameter int CACHE_LOG2 = 12,
  parameter int BLOCK_LOG2 = 4,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam logic [STAMP_W-1:0] CNT_INIT = STAMP_W'(1) << (CACHE_LOG2 - BLOCK_LOG2 + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  cmd_e                         cmd_i,
  input  logic [WAY_W-1:0]             way_i,
  input  logic [STAMP_W-1:0]           low_stamp_i,
  input  logic                         low_any_i,
  output logic [WAYS-1:0][STAMP_W-1:0] stamps_o,
  output logic [WAYS-1:0]              valid_o,
  output logic [STAMP_W-1:0]           cnt_o
);
  logic [WAYS-1:0][STAMP_W-1:0] stamps_q;
  logic [WAYS-1:0]              valid_q;
  logic [STAMP_W-1:0]           cnt_q;
  logic [STAMP_W-1:0]           new_stamp;
  logic                         do_write;

  always_comb begin
    new_stamp = cnt_q;
    do_write  = 1'b0;
    unique case (cmd_i)
      CMD_TOUCH:  do_write = valid_q[way_i];
      CMD_INS_HI: do_write = 1'b1;
      CMD_INS_LO: begin
        do_write  = 1'b1;
        new_stamp = low_any_i ? (low_stamp_i - STAMP_W'(1)) : cnt_q;
      end
      default:    do_write = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamps_q <= '0;
      valid_q  <= '0;
      cnt_q    <= CNT_INIT;
    end else if (do_write) begin
      stamps_q[way_i] <= new_stamp;
      valid_q[way_i]  <= 1'b1;
      cnt_q           <= cnt_q + STAMP_W'(1);
    end
  end

  assign stamps_o = stamps_q;
  assign valid_o  = valid_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/lru_stamp_tracker.sv
module lru_stamp_tracker
  import lru_stamp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int STAMP_W    = 32,
  parameter int CACHE_LOG2 = 12,
  parameter int BLOCK_LOG2 = 4,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [WAY_W-1:0]   touch_way_i,
  input  logic               ins_i,
  input  logic [WAY_W-1:0]   ins_way_i,
  input  logic               ins_low_i,
  input  logic [WAY_W-1:0]   rd_way_i,
  output logic [STAMP_W-1:0] rd_stamp_o,
  output logic [WAYS-1:0]    valid_o,
  output logic [WAY_W-1:0]   victim_o
);
  cmd_e                         cmd;
  logic [WAY_W-1:0]             cmd_way;
  logic [WAYS-1:0][STAMP_W-1:0] stamps;
  logic [WAYS-1:0]              valid;
  logic [STAMP_W-1:0]           cnt;
  logic [WAY_W-1:0]             oldest_idx;
  logic [STAMP_W-1:0]           oldest_stamp;
  logic                         oldest_any;

  // insert outranks touch
  always_comb begin
    if (ins_i)        cmd = ins_low_i ? CMD_INS_LO : CMD_INS_HI;
    else if (touch_i) cmd = CMD_TOUCH;
    else              cmd = CMD_IDLE;
    cmd_way = ins_i ? ins_way_i : touch_way_i;
  end

  lru_stamp_argmin #(.WAYS(WAYS), .STAMP_W(STAMP_W)) u_min (
    .stamps_i (stamps),
    .mask_i   (valid),
    .idx_o    (oldest_idx),
    .min_o    (oldest_stamp),
    .any_o    (oldest_any)
  );

  lru_stamp_victim #(.WAYS(WAYS)) u_vic (
    .valid_i  (valid),
    .oldest_i (oldest_idx),
    .victim_o (victim_o)
  );

  lru_stamp_store #(
    .WAYS(WAYS), .STAMP_W(STAMP_W),
    .CACHE_LOG2(CACHE_LOG2), .BLOCK_LOG2(BLOCK_LOG2)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .way_i       (cmd_way),
    .low_stamp_i (oldest_stamp),
    .low_any_i   (oldest_any),
    .stamps_o    (stamps),
    .valid_o     (valid),
    .cnt_o       (cnt)
  );

  assign rd_stamp_o = stamps[rd_way_i];
  assign valid_o    = valid;
endmodule

// File: rtl/lru_stamp_tracker_chk.sv
module lru_stamp_tracker_chk #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 32,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         touch_i,
  input logic [WAY_W-1:0]             touch_way_i,
  input logic                         ins_i,
  input logic [WAY_W-1:0]             ins_way_i,
  input logic                         ins_low_i,
  input logic [WAYS-1:0]              valid_i,
  input logic [WAY_W-1:0]             victim_i,
  input logic [WAYS-1:0][STAMP_W-1:0] stamps_i,
  input logic [STAMP_W-1:0]           cnt_i
);
  // R2
  touch_stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !ins_i && valid_i[touch_way_i]) |=> stamps_i[$past(touch_way_i)] == $past(cnt_i));

  // R3
  touch_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !ins_i && !valid_i[touch_way_i]) |=> ($stable(cnt_i) && $stable(valid_i) && $stable(stamps_i)));

  // R4
  ins_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !ins_low_i) |=> (stamps_i[$past(ins_way_i)] == $past(cnt_i) && valid_i[$past(ins_way_i)]));

  // R6
  ins_lo_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && ins_low_i && valid_i == '0) |=> stamps_i[$past(ins_way_i)] == $past(cnt_i));

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> cnt_i == $past(cnt_i) + STAMP_W'(1));

  // R7
  victim_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[victim_i]);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!touch_i && !ins_i) |=> ($stable(cnt_i) && $stable(valid_i)));

  for (genvar g = 0; g < WAYS; g++) begin : g_old
    // R8
    victim_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&valid_i) |-> stamps_i[victim_i] <= stamps_i[g]);
  end
endmodule

bind lru_stamp_tracker lru_stamp_tracker_chk #(.WAYS(WAYS), .STAMP_W(STAMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .touch_i     (touch_i),
  .touch_way_i (touch_way_i),
  .ins_i       (ins_i),
  .ins_way_i   (ins_way_i),
  .ins_low_i   (ins_low_i),
  .valid_i     (valid),
  .victim_i    (victim_o),
  .stamps_i    (stamps),
  .cnt_i       (cnt)
);

// File: tb/sim_lru_stamp_tracker.sv
`timescale 1ns/1ps
module sim_lru_stamp_tracker;
  localparam int WAYS = 4;
  localparam int SW   = 32;
  localparam int WW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          touch = 1'b0, ins = 1'b0, ins_low = 1'b0;
  logic [WW-1:0] touch_way = '0, ins_way = '0, rd_way = '0;
  logic [SW-1:0] rd_stamp;
  logic [WAYS-1:0] valid;
  logic [WW-1:0] victim;

  int tests = 0;
  int fails = 0;

  logic [SW-1:0] m_stamp [WAYS];
  logic          m_valid [WAYS];
  logic [SW-1:0] m_cnt;

  always #2.5 clk = ~clk;

  lru_stamp_tracker #(.WAYS(WAYS), .STAMP_W(SW), .CACHE_LOG2(12), .BLOCK_LOG2(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .touch_i(touch), .touch_way_i(touch_way),
    .ins_i(ins), .ins_way_i(ins_way), .ins_low_i(ins_low), .rd_way_i(rd_way),
    .rd_stamp_o(rd_stamp), .valid_o(valid), .victim_o(victim)
  );

  function automatic logic [WW-1:0] exp_victim();
    logic [WW-1:0] v = '0;
    logic [SW-1:0] best = '0;
    bit found = 0;
    for (int i = 0; i < WAYS; i++)
      if (!m_valid[i]) return WW'(i);
    for (int i = 0; i < WAYS; i++)
      if (!found || m_stamp[i] < best) begin
        best = m_stamp[i]; v = WW'(i); found = 1;
      end
    return v;
  endfunction

  function automatic logic [WAYS-1:0] exp_valid();
    logic [WAYS-1:0] r;
    for (int i = 0; i < WAYS; i++) r[i] = m_valid[i];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "valid", SW'(valid), SW'(exp_valid()));
    chk(req, "victim", SW'(victim), SW'(exp_victim()));
    for (int i = 0; i < WAYS; i++) begin
      rd_way = WW'(i);
      #0.2;
      chk(req, $sformatf("stamp%0d", i), rd_stamp, m_stamp[i]);
    end
  endtask

  task automatic model_step(logic t, logic [WW-1:0] tw, logic n, logic [WW-1:0] nw, logic lo);
    logic [SW-1:0] low = '0;
    bit any = 0;
    if (n) begin
      for (int i = 0; i < WAYS; i++)
        if (m_valid[i] && (!any || m_stamp[i] < low)) begin low = m_stamp[i]; any = 1; end
      m_stamp[nw] = (lo && any) ? low - 1 : m_cnt;
      m_valid[nw] = 1'b1;
      m_cnt = m_cnt + 1;
    end else if (t && m_valid[tw]) begin
      m_stamp[tw] = m_cnt;
      m_cnt = m_cnt + 1;
    end
  endtask

  task automatic step(string req, logic t, logic [WW-1:0] tw, logic n, logic [WW-1:0] nw, logic lo);
    @(negedge clk);
    touch = t; touch_way = tw; ins = n; ins_way = nw; ins_low = lo;
    @(posedge clk);
    model_step(t, tw, n, nw, lo);
    #1;
    touch = 0; ins = 0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < WAYS; i++) begin m_stamp[i] = '0; m_valid[i] = 1'b0; end
    m_cnt = 32'd512;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R10: idle cycle holds state
    step("R10", 0, 0, 0, 0, 0);
    step("R3", 1, 2, 0, 0, 0);
    step("R6", 0, 0, 1, 1, 1);   // way1 <- 512
    step("R4", 0, 0, 1, 3, 0);   // way3 <- 513, counter unaffected by R3
    step("R7", 0, 0, 0, 0, 0);   // victim way0
    step("R5", 0, 0, 1, 0, 1);   // way0 <- 511
    step("R4", 0, 0, 1, 2, 0);   // way2 <- 515, set full
    step("R8", 0, 0, 0, 0, 0);   // victim way0
    step("R2", 1, 0, 0, 0, 0);   // way0 <- 516
    step("R8", 0, 0, 0, 0, 0);   // victim way1
    step("R9", 1, 3, 1, 1, 1);   // way1 <- 511, touch dropped
    step("R5", 0, 0, 1, 2, 1);   // way2 <- 510
    // second reset, then random traffic
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < WAYS; i++) begin m_stamp[i] = '0; m_valid[i] = 1'b0; end
    m_cnt = 32'd512;
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 9);
      logic [WW-1:0] a = WW'($urandom_range(0, WAYS - 1));
      logic [WW-1:0] b = WW'($urandom_range(0, WAYS - 1));
      if (op < 4)       step("R2", 1, a, 0, 0, 0);
      else if (op < 6)  step("R4", 0, 0, 1, b, 0);
      else if (op < 8)  step("R5", 0, 0, 1, b, 1);
      else if (op == 8) step("R9", 1, a, 1, b, $urandom_range(0, 1) == 1);
      else              step("R8", 0, 0, 0, 0, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule